// File: doc/BRIEF.md
# Warp Branch Divergence Mask Stack

This block tracks which of the 32 lanes of a single warp are enabled while the warp runs through conditional branches. Every issued instruction advances the warp's program counter. When the instruction is a branch, the block receives a per-lane predicate, the target for lanes whose predicate is set, the target for the remaining lanes, and the PC where both paths meet again. If every enabled lane agrees, only the PC moves. If they disagree, the block saves a frame and runs the predicate-true lanes first. When execution reaches the meeting PC it switches to the predicate-false lanes, and on the next arrival it restores the mask that was in force before the branch.

Frames nest in last-in, first-out order, so an inner branch always rejoins before an outer one. Each arrival at a meeting PC takes one cycle in which `hold` is high and the issue inputs are ignored. The active-lane count is provided with each instruction so that lane-utilization efficiency can be measured. A branch that would need a frame while the stack is full sets a sticky overflow flag and is dropped.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset `pc` equals RESET_PC, `active_mask` is all ones, `depth` is 0, and `hold` and `overflow` are 0.
- R2: A non-branch issue (`step_valid`=1, `is_branch`=0, `hold`=0) sets `pc` to `pc`+1 on the next cycle and leaves the mask and depth unchanged.
- R3: A branch for which `br_pred & active_mask` equals `active_mask` sets `pc` to `br_taken_pc`. The mask and depth are unchanged.
- R4: A branch for which `br_pred & active_mask` is zero sets `pc` to `br_fall_pc`. The mask and depth are unchanged.
- R5: A branch for which `br_pred & active_mask` is neither zero nor `active_mask` pushes a frame and increases `depth` by 1. It sets the mask to `br_pred & active_mask` and `pc` to `br_taken_pc`. Bit i of every mask and predicate belongs to lane i.
- R6: When `depth`>0 and `pc` equals the top frame's meeting PC while its false-path is still pending, `hold` is 1. On the next cycle `pc` is the saved false-path target, the mask is the pre-branch mask with the predicate-true lanes cleared, and `depth` is unchanged.
- R7: When `depth`>0 and `pc` equals the top frame's meeting PC with no false-path pending, `hold` is 1. On the next cycle the pre-branch mask is restored, `pc` stays at the meeting PC, and `depth` drops by 1.
- R8: While `hold` is 1, `step_valid` and all branch inputs have no effect.
- R9: A divergent branch issued while `depth` equals DEPTH sets `overflow`. The flag stays set until reset. `pc`, the mask and `depth` are unchanged.
- R10: `active_count` always equals the number of set bits in `active_mask`.
- R11: Nested divergent branches rejoin innermost first, and each level restores the mask in force before its own branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | An instruction issues at `pc` this cycle |
| is_branch | input | 1 | The issued instruction is a conditional branch |
| br_pred | input | 32 | Per-lane branch predicate, bit i for lane i |
| br_taken_pc | input | 32 | Target for lanes whose predicate is 1 |
| br_fall_pc | input | 32 | Target for lanes whose predicate is 0 |
| br_reconv_pc | input | 32 | PC where both paths meet again |
| pc | output | 32 | Next PC the warp fetches |
| active_mask | output | 32 | Lanes enabled for the instruction at `pc` |
| active_count | output | 6 | Number of enabled lanes |
| hold | output | 1 | Meeting-point cycle; issue inputs are ignored |
| depth | output | 4 | Number of saved frames |
| overflow | output | 1 | Sticky flag for a push attempt into a full stack |

## Verification
The branch logic is driven with four kinds of predicate. An all-ones predicate and an all-zero predicate distinguish the two uniform outcomes, which must never push a frame. Random predicates mostly split the warp, and predicates restricted to the current mask separate lanes that are already disabled from lanes that are active. Directed sequences cover a single split and its two meeting-point cycles, branch inputs driven during `hold`, two nested levels that must rejoin innermost first, and a run of nine nested splits that fills the stack. Random programs place every meeting PC at or below the enclosing one, so every frame is eventually popped and the LIFO order is checked over thousands of cycles.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int LANES = 32;
    localparam int PC_W  = 32;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    // One saved divergence frame
    typedef struct packed {
        pc_t        reconv;
        lane_mask_t saved;
        pc_t        else_pc;
        lane_mask_t else_mask;
        logic       pend;
    } frame_t;

    // Registered warp state
    typedef struct packed {
        pc_t        pc;
        lane_mask_t mask;
        logic       ovf;
    } warp_state_t;

    typedef enum logic [2:0] {
        ACT_IDLE, ACT_SEQ, ACT_UNIFORM, ACT_PUSH, ACT_OVF, ACT_ELSE, ACT_POP
    } act_e;

endpackage

// File: rtl/lane_popcount.sv
module lane_popcount #(
    parameter int N = 32,
    localparam int W = $clog2(N + 1)
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] count
);

    logic [W-1:0] part [N+1];

    assign part[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_add
            assign part[gi+1] = part[gi] + {{(W-1){1'b0}}, bits[gi]};
        end
    endgenerate

    assign count = part[N];

endmodule

// File: rtl/branch_classify.sv
module branch_classify
    import simt_pkg::*;
(
    input  lane_mask_t active,
    input  lane_mask_t pred,
    output lane_mask_t taken_mask,
    output lane_mask_t else_mask,
    output logic       all_take,
    output logic       none_take,
    output logic       split
);

    always_comb begin
        taken_mask = pred & active;
        else_mask  = active & ~pred;
        all_take   = (taken_mask == active);
        none_take  = (taken_mask == '0);
        split      = !all_take && !none_take;
    end

endmodule

// File: rtl/frame_stack.sv
module frame_stack
    import simt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  frame_t           push_frame,
    input  logic             pop,
    input  logic             clear_pend,
    output frame_t           top,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    frame_t           ent_q [DEPTH];
    frame_t           ent_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        top_idx = IDX_W'(cnt_q - CNT_W'(1));
        wr_idx  = IDX_W'(cnt_q);
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNT_W'(DEPTH));
        top     = empty ? '0 : ent_q[top_idx];
        count   = cnt_q;
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        cnt_d = cnt_q;
        if (push && !full) begin
            ent_d[wr_idx] = push_frame;
            cnt_d         = cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else if (clear_pend && !empty) begin
            ent_d[top_idx].pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full)); // R9
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R7
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push, pop, clear_pend}) <= 1); // R11

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int RESET_PC = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_valid,
    input  logic                       is_branch,
    input  logic [31:0]                br_pred,
    input  logic [31:0]                br_taken_pc,
    input  logic [31:0]                br_fall_pc,
    input  logic [31:0]                br_reconv_pc,
    output logic [31:0]                pc,
    output logic [31:0]                active_mask,
    output logic [5:0]                 active_count,
    output logic                       hold,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic                       overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int POP_W = $clog2(LANES + 1);

    warp_state_t      state_q, state_d;
    act_e             act;
    lane_mask_t       taken_mask, else_mask;
    logic             all_take, none_take, split;
    frame_t           top, new_frame;
    logic [CNT_W-1:0] cnt;
    logic             full, empty;
    logic             push, pop, clr;
    logic             at_reconv;
    logic [POP_W-1:0] pop_cnt;

    branch_classify u_cls (
        .active     (state_q.mask),
        .pred       (br_pred),
        .taken_mask (taken_mask),
        .else_mask  (else_mask),
        .all_take   (all_take),
        .none_take  (none_take),
        .split      (split)
    );

    frame_stack #(.DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_frame (new_frame),
        .pop        (pop),
        .clear_pend (clr),
        .top        (top),
        .count      (cnt),
        .full       (full),
        .empty      (empty)
    );

    lane_popcount #(.N(LANES)) u_pop (
        .bits  (state_q.mask),
        .count (pop_cnt)
    );

    always_comb begin
        state_d   = state_q;
        act       = ACT_IDLE;
        at_reconv = !empty && (state_q.pc == top.reconv);
        new_frame = '{reconv: br_reconv_pc, saved: state_q.mask,
                      else_pc: br_fall_pc, else_mask: else_mask, pend: 1'b1};

        if (at_reconv) begin
            act = top.pend ? ACT_ELSE : ACT_POP;
        end else if (step_valid) begin
            if (!is_branch)      act = ACT_SEQ;
            else if (!split)     act = ACT_UNIFORM;
            else if (full)       act = ACT_OVF;
            else                 act = ACT_PUSH;
        end

        push = (act == ACT_PUSH);
        pop  = (act == ACT_POP);
        clr  = (act == ACT_ELSE);

        unique case (act)
            ACT_SEQ:     state_d.pc = state_q.pc + PC_W'(1);
            ACT_UNIFORM: state_d.pc = all_take ? br_taken_pc : br_fall_pc;
            ACT_PUSH: begin
                state_d.pc   = br_taken_pc;
                state_d.mask = taken_mask;
            end
            ACT_OVF:     state_d.ovf = 1'b1;
            ACT_ELSE: begin
                state_d.pc   = top.else_pc;
                state_d.mask = top.else_mask;
            end
            ACT_POP:     state_d.mask = top.saved;
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc   <= PC_W'(RESET_PC);
            state_q.mask <= '1;
            state_q.ovf  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc           = state_q.pc;
    assign active_mask  = state_q.mask;
    assign active_count = pop_cnt;
    assign hold         = at_reconv;
    assign depth        = cnt;
    assign overflow     = state_q.ovf;

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0); // R5
    AST_UNIFORM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && is_branch && !hold &&
         (((br_pred & active_mask) == active_mask) || ((br_pred & active_mask) == '0)))
        |=> ($stable(active_mask) && $stable(depth))); // R3
    AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && is_branch && !hold && depth != CNT_W'(DEPTH) &&
         ((br_pred & active_mask) != '0) && ((br_pred & active_mask) != active_mask))
        |=> (depth == $past(depth) + CNT_W'(1) &&
             (active_mask & ~$past(active_mask)) == '0 &&
             active_mask != $past(active_mask))); // R5
    AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && is_branch && !hold && depth == CNT_W'(DEPTH) &&
         ((br_pred & active_mask) != '0) && ((br_pred & active_mask) != active_mask))
        |=> (overflow && $stable(pc) && $stable(active_mask) && $stable(depth))); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
    AST_HOLD_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (depth <= $past(depth))); // R8
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        active_count == POP_W'($countones(active_mask))); // R10

endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0, is_branch = 1'b0;
    logic [31:0] br_pred = '0, br_taken_pc = '0, br_fall_pc = '0, br_reconv_pc = '0;
    logic [31:0] pc, active_mask;
    logic [5:0]  active_count;
    logic        hold, overflow;
    logic [3:0]  depth;

    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    simt_mask_stack #(.DEPTH(DEPTH), .RESET_PC(0)) u0 (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .is_branch(is_branch),
        .br_pred(br_pred), .br_taken_pc(br_taken_pc), .br_fall_pc(br_fall_pc),
        .br_reconv_pc(br_reconv_pc), .pc(pc), .active_mask(active_mask),
        .active_count(active_count), .hold(hold), .depth(depth), .overflow(overflow)
    );

    // Reference model state
    logic [31:0] m_pc, m_mask;
    int          m_dep;
    logic        m_ovf;
    logic [31:0] s_rc [DEPTH], s_sm [DEPTH], s_ep [DEPTH], s_em [DEPTH];
    logic        s_pd [DEPTH];
    string       m_tag;

    function automatic logic m_hold();
        return (m_dep > 0) && (m_pc == s_rc[m_dep-1]);
    endfunction

    task automatic model(input logic st, input logic br, input logic [31:0] pr,
                         input logic [31:0] t, input logic [31:0] f, input logic [31:0] r);
        logic [31:0] e;
        e = pr & m_mask;
        if (m_hold()) begin
            if (s_pd[m_dep-1]) begin
                m_pc = s_ep[m_dep-1]; m_mask = s_em[m_dep-1]; s_pd[m_dep-1] = 1'b0;
                m_tag = "R6";
            end else begin
                m_mask = s_sm[m_dep-1]; m_dep--; m_tag = "R7";
            end
            if (st) m_tag = "R8";
        end else if (st) begin
            if (!br) begin m_pc++; m_tag = "R2"; end
            else if (e == m_mask) begin m_pc = t; m_tag = "R3"; end
            else if (e == 0) begin m_pc = f; m_tag = "R4"; end
            else if (m_dep == DEPTH) begin m_ovf = 1'b1; m_tag = "R9"; end
            else begin
                s_rc[m_dep] = r; s_sm[m_dep] = m_mask; s_ep[m_dep] = f;
                s_em[m_dep] = m_mask & ~pr; s_pd[m_dep] = 1'b1; m_dep++;
                m_mask = e; m_pc = t; m_tag = "R5";
            end
        end else m_tag = "R2";
    endtask

    task automatic chk(input string tag, input string nm, input logic [31:0] a, input logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, a, e);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "mask", active_mask, m_mask);
        chk(tag, "depth", 32'(depth), 32'(m_dep));
        chk(tag, "hold", 32'(hold), 32'(m_hold()));
        chk(tag, "overflow", 32'(overflow), 32'(m_ovf));
        chk("R10", "count", 32'(active_count), 32'($countones(m_mask)));
    endtask

    // Called at a negedge: drive, model, advance, check at next negedge
    task automatic cyc(input logic st, input logic br, input logic [31:0] pr,
                       input logic [31:0] t, input logic [31:0] f, input logic [31:0] r,
                       input string ovr);
        step_valid = st; is_branch = br; br_pred = pr;
        br_taken_pc = t; br_fall_pc = f; br_reconv_pc = r;
        model(st, br, pr, t, f, r);
        @(posedge clk);
        @(negedge clk);
        check_all(ovr == "" ? m_tag : ovr);
    endtask

    task automatic seq(input string ovr);
        cyc(1'b1, 1'b0, '0, '0, '0, '0, ovr);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_pc = 0; m_mask = '1; m_dep = 0; m_ovf = 1'b0; m_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: sequential issue
        repeat (3) seq("");
        // R3: uniform taken
        cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 32'd100, 32'd200, 32'd300, "R3");
        // R4: uniform not taken
        cyc(1'b1, 1'b1, 32'h0, 32'd500, 32'd150, 32'd600, "R4");
        // R5: split, then run to meeting point
        cyc(1'b1, 1'b1, 32'h0000_FFFF, 32'd151, 32'd155, 32'd160, "R5");
        while (!m_hold()) seq("R2");
        // R8 + R6: branch driven during hold is ignored, false path starts
        cyc(1'b1, 1'b1, 32'h0, 32'd900, 32'd901, 32'd902, "R8");
        chk("R6", "pc", pc, 32'd155);
        chk("R6", "mask", active_mask, 32'hFFFF_0000);
        while (!m_hold()) seq("R2");
        cyc(1'b0, 1'b0, '0, '0, '0, '0, "R7");
        chk("R7", "mask", active_mask, 32'hFFFF_FFFF);
        chk("R7", "depth", 32'(depth), 32'd0);

        // R11: two nested levels
        cyc(1'b1, 1'b1, 32'h00FF_00FF, 32'd161, 32'd170, 32'd180, "R11");
        cyc(1'b1, 1'b1, 32'h0000_000F, 32'd162, 32'd165, 32'd168, "R11");
        chk("R11", "mask", active_mask, 32'h0000_000F);
        while (m_dep > 0) seq("R11");
        chk("R11", "pc", pc, 32'd180);
        chk("R11", "mask", active_mask, 32'hFFFF_FFFF);

        // R9: nine nested splits into an eight-deep stack
        for (int k = 0; k < DEPTH + 1; k++) begin
            cyc(1'b1, 1'b1, m_mask & (m_mask - 32'd1), m_pc + 32'd1,
                32'd220, 32'd220, "");
        end
        chk("R9", "overflow", 32'(overflow), 32'd1);
        chk("R9", "depth", 32'(depth), 32'(DEPTH));
        while (m_dep > 0) seq("");

        // Random programs, meeting PCs nested within the enclosing one
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic        st, br;
            logic [31:0] lim, rem, r, f, pr;
            st  = ($urandom % 100) < 85;
            lim = (m_dep > 0) ? s_rc[m_dep-1] : m_pc + 32'd64;
            rem = lim - m_pc;
            br  = (rem >= 3) && (($urandom % 100) < 35);
            r   = m_pc + 32'd2 + ((rem >= 3) ? ($urandom % (rem - 1)) : 32'd0);
            f   = m_pc + 32'd1 + ($urandom % (r - m_pc));
            case ($urandom % 4)
                0:       pr = '1;
                1:       pr = '0;
                2:       pr = $urandom;
                default: pr = m_mask & $urandom;
            endcase
            cyc(st, br, pr, m_pc + 32'd1, f, r, "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule